// File: doc/BRIEF.md
# Bridge Output Fault Supervisor

This block watches a two-phase power bridge and reports two status conditions to the controller. The first is a short-circuit flag. For every phase that is being actively driven, the block compares the level that was asked for with a digital reading of the real output level. When the two differ on any phase, the flag rises. Each time the controller changes its drive commands it pulses a strobe. The strobe opens a blanking window of a fixed number of clock cycles, and during that window comparisons are ignored so that normal switching edges are not reported as faults.

The second condition is an over-temperature warning, taken from an 8-bit die-temperature code in degrees Celsius. The warning uses two thresholds. It rises once the code reaches the upper one, and it falls only after the code drops below the lower one. Neither flag has any effect on the drive. Both are plain registered outputs, and the controller decides what to do about them.

Top module: `bridge_fault_watch`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `short_flag_o` and `hot_flag_o` are both 0.
- R2: Each phase takes a 2-bit command in `cmd_state_i[2p+1:2p]`. The code 2'b10 means drive high and expects sense level 1. The code 2'b01 means drive low and expects sense level 0. If an unblanked cycle shows the sensed level differing from what is expected, `short_flag_o` is 1 after the next clock edge.
- R3: A phase commanded 2'b00 (floating) or 2'b11 (both switches requested, which the bridge treats as off) is not compared. Such a phase can never raise `short_flag_o`.
- R4: `short_flag_o` is the OR of the comparison results of all phases. A mismatch on either phase alone is enough to raise it.
- R5: When `cmd_chg_i` is 1 in a cycle, comparisons are ignored in that cycle and in the following BLANK_CYC cycles. While they are ignored, `short_flag_o` is 0 after each clock edge (20 cycles by default).
- R6: A `cmd_chg_i` pulse that arrives during an open blanking window starts the full window again from that pulse.
- R7: The short flag does not latch. After an unblanked cycle with no mismatch, `short_flag_o` is 0 after the next edge.
- R8: While `hot_flag_o` is 0, a temperature code at or above HOT_SET (135 by default) sets it at the next edge. Any code below HOT_SET leaves it at 0.
- R9: While `hot_flag_o` is 1, it stays 1 for any code at or above HOT_CLR (95 by default). It clears at the next edge once the code is below HOT_CLR.
- R10: The two flags are independent of each other. Blanking and command changes have no effect on `hot_flag_o`, so both flags can be 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_state_i | input | 2*N_PH | Per-phase drive command: 00 float, 01 low, 10 high, 11 off |
| sense_lvl_i | input | N_PH | Sensed digital level of each phase output |
| cmd_chg_i | input | 1 | Strobe, high for a cycle whenever commands change |
| temp_code_i | input | TEMP_W | Die temperature in degrees Celsius, unsigned |
| short_flag_o | output | 1 | Output disagrees with command (registered) |
| hot_flag_o | output | 1 | Over-temperature warning with hysteresis (registered) |

## Verification
Two events can land on the same clock edge: a command-change strobe and an output mismatch that would otherwise be reported. The bench provokes this in two ways. It holds a mismatch steady while pulsing the strobe, and it re-pulses the strobe just before a window closes. It then expects the flag to stay low for exactly BLANK_CYC+1 edges, counted from the last pulse. The thermal flag is also driven across its band while blanking is active, and it must follow its own thresholds on the same edges that the short flag is being held low.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

  typedef enum logic [1:0] {
    DRV_FLOAT = 2'b00,
    DRV_LOW   = 2'b01,
    DRV_HIGH  = 2'b10,
    DRV_OFF   = 2'b11
  } drv_cmd_e;

  // A phase is compared only while one switch is actively driving it.
  function automatic logic drv_is_active(input drv_cmd_e cmd);
    return (cmd == DRV_LOW) || (cmd == DRV_HIGH);
  endfunction

  function automatic logic drv_expected_lvl(input drv_cmd_e cmd);
    return (cmd == DRV_HIGH);
  endfunction

endpackage

// File: rtl/bfw_blank_timer.sv
module bfw_blank_timer #(
  parameter int BLANK_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic blank_o
);

  localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          busy;

  assign busy = (cnt_q != '0);

  // Window covers the strobe cycle itself plus the BLANK_CYC cycles after it.
  assign blank_o = restart_i | busy;

  always_comb begin
    cnt_en = restart_i | busy;
    cnt_d  = cnt_q;
    if (restart_i) begin
      cnt_d = LOAD_V;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bfw_phase_cmp.sv
module bfw_phase_cmp
  import bfw_pkg::*;
(
  input  logic [1:0] cmd_i,
  input  logic       sense_i,
  output logic       mism_o
);

  drv_cmd_e cmd;
  logic     active;
  logic     want_lvl;

  assign cmd      = drv_cmd_e'(cmd_i);
  assign active   = drv_is_active(cmd);
  assign want_lvl = drv_expected_lvl(cmd);
  assign mism_o   = active & (sense_i != want_lvl);

endmodule

// File: rtl/bfw_thermal_hyst.sv
module bfw_thermal_hyst #(
  parameter int TEMP_W  = 8,
  parameter int HOT_SET = 135,
  parameter int HOT_CLR = 95
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);

  localparam logic [TEMP_W-1:0] SET_V = TEMP_W'(HOT_SET);
  localparam logic [TEMP_W-1:0] CLR_V = TEMP_W'(HOT_CLR);

  logic hot_q, hot_d, hot_en;
  logic at_set, below_clr;

  assign at_set    = (temp_i >= SET_V);
  assign below_clr = (temp_i <  CLR_V);

  always_comb begin
    hot_d  = hot_q;
    hot_en = 1'b0;
    if (!hot_q && at_set) begin
      hot_d  = 1'b1;
      hot_en = 1'b1;
    end else if (hot_q && below_clr) begin
      hot_d  = 1'b0;
      hot_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= 1'b0;
    end else if (hot_en) begin
      hot_q <= hot_d;
    end
  end

  assign hot_o = hot_q;

endmodule

// File: rtl/bridge_fault_watch.sv
module bridge_fault_watch #(
  parameter int N_PH      = 2,
  parameter int BLANK_CYC = 20,
  parameter int TEMP_W    = 8,
  parameter int HOT_SET   = 135,
  parameter int HOT_CLR   = 95
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*N_PH-1:0]   cmd_state_i,
  input  logic [N_PH-1:0]     sense_lvl_i,
  input  logic                cmd_chg_i,
  input  logic [TEMP_W-1:0]   temp_code_i,
  output logic                short_flag_o,
  output logic                hot_flag_o
);

  logic [N_PH-1:0] ph_mism;
  logic            blank;
  logic            any_mism;
  logic            short_q, short_d, short_en;

  bfw_blank_timer #(
    .BLANK_CYC(BLANK_CYC)
  ) u_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cmd_chg_i),
    .blank_o  (blank)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    bfw_phase_cmp u_cmp (
      .cmd_i  (cmd_state_i[2*p +: 2]),
      .sense_i(sense_lvl_i[p]),
      .mism_o (ph_mism[p])
    );
  end

  assign any_mism = |ph_mism;

  always_comb begin
    short_d  = any_mism & ~blank;
    short_en = (short_d != short_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_q <= 1'b0;
    end else if (short_en) begin
      short_q <= short_d;
    end
  end

  assign short_flag_o = short_q;

  bfw_thermal_hyst #(
    .TEMP_W (TEMP_W),
    .HOT_SET(HOT_SET),
    .HOT_CLR(HOT_CLR)
  ) u_therm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .temp_i(temp_code_i),
    .hot_o (hot_flag_o)
  );

endmodule

// File: rtl/bridge_fault_watch_chk.sv
module bridge_fault_watch_chk #(
  parameter int N_PH      = 2,
  parameter int BLANK_CYC = 20,
  parameter int TEMP_W    = 8,
  parameter int HOT_SET   = 135,
  parameter int HOT_CLR   = 95
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*N_PH-1:0]   cmd_state_i,
  input logic [N_PH-1:0]     sense_lvl_i,
  input logic                cmd_chg_i,
  input logic [TEMP_W-1:0]   temp_code_i,
  input logic                short_flag_o,
  input logic                hot_flag_o
);

  localparam int QW = $clog2(BLANK_CYC + 2);
  localparam logic [QW-1:0] Q_MAX = QW'(BLANK_CYC);
  localparam logic [TEMP_W-1:0] SET_V = TEMP_W'(HOT_SET);
  localparam logic [TEMP_W-1:0] CLR_V = TEMP_W'(HOT_CLR);

  // Cycles since the last strobe, saturating at BLANK_CYC.
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= Q_MAX;
    end else if (cmd_chg_i) begin
      quiet_q <= '0;
    end else if (quiet_q < Q_MAX) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  logic port_mism, all_idle;
  always_comb begin
    port_mism = 1'b0;
    all_idle  = 1'b1;
    for (int p = 0; p < N_PH; p++) begin
      case (cmd_state_i[2*p +: 2])
        2'b01: begin all_idle = 1'b0; if (sense_lvl_i[p])  port_mism = 1'b1; end
        2'b10: begin all_idle = 1'b0; if (!sense_lvl_i[p]) port_mism = 1'b1; end
        default: ;
      endcase
    end
  end

  p_mismatch_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_chg_i && quiet_q >= Q_MAX && port_mism) |=> short_flag_o);

  p_idle_no_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle |=> !short_flag_o);

  p_strobe_blanks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_chg_i |=> !short_flag_o);

  p_window_blanks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q < Q_MAX) |=> !short_flag_o);

  p_no_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_mism |=> !short_flag_o);

  p_hot_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hot_flag_o && temp_code_i >= SET_V) |=> hot_flag_o);

  p_cool_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hot_flag_o && temp_code_i < SET_V) |=> !hot_flag_o);

  p_hot_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_flag_o && temp_code_i >= CLR_V) |=> hot_flag_o);

  p_hot_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_flag_o && temp_code_i < CLR_V) |=> !hot_flag_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_low_r1: assert (!short_flag_o && !hot_flag_o);
    end
  end

endmodule

bind bridge_fault_watch bridge_fault_watch_chk #(
  .N_PH     (N_PH),
  .BLANK_CYC(BLANK_CYC),
  .TEMP_W   (TEMP_W),
  .HOT_SET  (HOT_SET),
  .HOT_CLR  (HOT_CLR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_state_i (cmd_state_i),
  .sense_lvl_i (sense_lvl_i),
  .cmd_chg_i   (cmd_chg_i),
  .temp_code_i (temp_code_i),
  .short_flag_o(short_flag_o),
  .hot_flag_o  (hot_flag_o)
);

// File: tb/sim_bridge_fault_watch.sv
module sim_bridge_fault_watch;

  localparam int CLK_PERIOD = 10;
  localparam int N_PH       = 2;
  localparam int BLANK_CYC  = 20;
  localparam int TEMP_W     = 8;
  localparam int HOT_SET    = 135;
  localparam int HOT_CLR    = 95;
  localparam int WDOG_CYC   = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [2*N_PH-1:0] cmd;
  logic [N_PH-1:0]   sense;
  logic              chg;
  logic [TEMP_W-1:0] temp;
  logic              short_flag, hot_flag;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_fault_watch #(
    .N_PH(N_PH), .BLANK_CYC(BLANK_CYC), .TEMP_W(TEMP_W),
    .HOT_SET(HOT_SET), .HOT_CLR(HOT_CLR)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_state_i(cmd), .sense_lvl_i(sense),
    .cmd_chg_i(chg), .temp_code_i(temp),
    .short_flag_o(short_flag), .hot_flag_o(hot_flag)
  );

  // Reference state
  int   m_blank;
  logic exp_short, exp_hot;

  function automatic logic f_mism(input logic [2*N_PH-1:0] c, input logic [N_PH-1:0] s);
    logic m = 1'b0;
    for (int p = 0; p < N_PH; p++) begin
      if (c[2*p +: 2] == 2'b01 && s[p] != 1'b0) m = 1'b1;
      if (c[2*p +: 2] == 2'b10 && s[p] != 1'b1) m = 1'b1;
    end
    return m;
  endfunction

  function automatic logic f_hot(input logic cur, input logic [TEMP_W-1:0] t);
    if (cur) return (int'(t) >= HOT_CLR);
    return (int'(t) >= HOT_SET);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge with inputs already set; advances one cycle.
  task automatic step(input string ts, input string th);
    logic nx_s, nx_h, blk;
    blk  = chg || (m_blank != 0);
    nx_s = f_mism(cmd, sense) && !blk;
    nx_h = f_hot(exp_hot, temp);
    @(posedge clk);
    m_blank   = chg ? BLANK_CYC : ((m_blank > 0) ? m_blank - 1 : 0);
    exp_short = nx_s;
    exp_hot   = nx_h;
    @(negedge clk);
    check(short_flag, exp_short, ts);
    check(hot_flag, exp_hot, th);
  endtask

  initial begin : wdog
    for (int i = 0; i < WDOG_CYC; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    rst_n = 1'b0; cmd = '0; sense = '0; chg = 1'b0; temp = 8'd25;
    m_blank = 0; exp_short = 1'b0; exp_hot = 1'b0;
    repeat (3) @(negedge clk);
    check(short_flag, 1'b0, "R1 short in reset");
    check(hot_flag, 1'b0, "R1 hot in reset");
    // mismatch and heat present during reset: flags must still be low
    cmd = 4'b0010; sense = 2'b00; temp = 8'd200;
    @(negedge clk);
    check(short_flag, 1'b0, "R1 short in reset w/ stimulus");
    check(hot_flag, 1'b0, "R1 hot in reset w/ stimulus");
    cmd = '0; temp = 8'd25;
    rst_n = 1'b1;
    step("R1 short after release", "R1 hot after release");

    // R2: drive high but sensed low on phase 0
    cmd = {2'b00, 2'b10}; sense = 2'b00;
    step("R2 high cmd low sense", "R10 hot");
    sense = 2'b01;
    step("R7 clears when matched", "R10 hot");
    cmd = {2'b01, 2'b00}; sense = 2'b10;
    step("R2 low cmd high sense ph1", "R10 hot");
    // R3: floating and both-on never compared
    cmd = {2'b00, 2'b11}; sense = 2'b10;
    step("R3 idle phases", "R10 hot");
    sense = 2'b01;
    step("R3 idle phases", "R10 hot");
    // R4: either phase alone
    cmd = {2'b10, 2'b10}; sense = 2'b01;
    step("R4 ph1 only", "R10 hot");
    sense = 2'b10;
    step("R4 ph0 only", "R10 hot");
    sense = 2'b11;
    step("R7 no latch", "R10 hot");

    // R5: strobe with a standing mismatch, exact window length
    sense = 2'b00; chg = 1'b1; temp = 8'd135;
    step("R5 strobe cycle", "R8 set at threshold");
    chg = 1'b0;
    for (int i = 0; i < BLANK_CYC; i++) begin
      temp = (i % 2 == 0) ? 8'd95 : 8'd134;
      step("R5 inside window", "R9 hold in band");
    end
    step("R5 window over, R10 both high", "R10 hot with short");

    // R6: restart near window end
    chg = 1'b1;
    step("R6 strobe", "R10 hot");
    chg = 1'b0;
    for (int i = 0; i < BLANK_CYC - 2; i++) step("R6 window", "R10 hot");
    chg = 1'b1;
    step("R6 re-strobe", "R10 hot");
    chg = 1'b0;
    for (int i = 0; i < BLANK_CYC; i++) step("R6 restarted window", "R10 hot");
    step("R6 restarted window over", "R10 hot");

    // R9 clear edge, R8 just below set
    temp = 8'd94;
    step("R2 standing mismatch", "R9 clear below low threshold");
    temp = 8'd134;
    step("R2 standing mismatch", "R8 no set below threshold");
    temp = 8'd255;
    step("R2 standing mismatch", "R8 set at max");
    temp = 8'd0;
    step("R2 standing mismatch", "R9 clear at zero");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      cmd   = ($urandom % 4 == 0) ? cmd : 4'($urandom);
      sense = 2'($urandom);
      chg   = ($urandom % 16 == 0);
      if ($urandom % 8 == 0) temp = 8'($urandom);
      else temp = 8'(int'(temp) + int'($urandom % 7) - 3);
      step("R2 R3 R4 R5 R6 R7 random", "R8 R9 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule